// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block keeps the interrupt state of a small byte-wide peripheral that has sixteen registers. It holds an 8-bit flag register and an 8-bit enable register, takes one-cycle event pulses from two internal sources (a timer underflow and a shift-register byte event), and drives one registered interrupt request line. It also extracts the 4-bit register index from the bus address so that neighbouring logic can share the decode.

Software clears flags by writing ones to the flag register. The enable register is written with a mode bit: bit 7 selects whether the ones in bits 6:0 are set or cleared. Reading either byte of the timer counter also clears the timer flag, so a timer service routine needs no separate acknowledge. Only the shift-register source can raise the request line. The timer flag is visible to software but does not drive the line.

Top module: `ifc_ctrl`

## Requirements
- R1: The register index is address bits 12:9 (4 bits, indexes 0 to 15) and is output on `reg_sel`. Only index 13 (flags) and index 14 (enables) change state on a write. A write to any other index has no effect on either register.
- R2: A write to index 14 with data bit 7 = 1 ORs data bits 6:0 into the enables. Enable bit 7 always stays 0.
- R3: A write to index 14 with data bit 7 = 0 clears each enable bit whose data bit is 1 and leaves the others unchanged.
- R4: A write to index 13 clears each flag bit whose data bit is 1 and leaves the other flag bits unchanged.
- R5: A `timer_evt` pulse sets flag bit 6 and a `shift_evt` pulse sets flag bit 2. No other flag bit can ever become 1.
- R6: A read strobe at index 4 or 5 clears flag bit 6. A read at any other index changes no state.
- R7: When a set pulse and a clear (flag write or read-clear) hit the same flag bit in one cycle, the flag ends up set.
- R8: `irq` is registered. In each cycle it equals (flag bit 2 AND enable bit 2) as held in the previous cycle. Flag bit 6 and enable bit 6 have no effect on `irq`.
- R9: While `rst_n` is low, both registers and `irq` are 0.
- R10: `bus_rdata` shows the flags when the index is 13 and the enables when the index is 14. For every other index it shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address, register index in bits 12:9 |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the flag and enable registers |
| timer_evt | input | 1 | Timer underflow pulse, sets flag bit 6 |
| shift_evt | input | 1 | Shift-register byte pulse, sets flag bit 2 |
| reg_sel | output | 4 | Decoded register index |
| irq | output | 1 | Registered interrupt request |

## Verification
Random cycles mix writes and reads to every index, with random address bits outside 12:9 and random event pulses. A bench model predicts the flags, enables and `irq`, so the run separates correct index decoding from decoding that looks at the wrong address bits, and set-mode enable writes from clear-mode ones. Directed cases put an event and a clear on the same bit in one cycle, which separates set-wins from clear-wins. They also read index 6 next to indexes 4 and 5, to confine read-clearing to the counter bytes, and raise the timer flag with its enable set, to show that `irq` follows only the shift source.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int unsigned SEL_W      = 4;
  localparam int unsigned IDX_FLAGS  = 13;
  localparam int unsigned IDX_ENABLE = 14;
  localparam int unsigned IDX_CNT_LO = 4;
  localparam int unsigned IDX_CNT_HI = 5;
  localparam int unsigned BIT_TIMER  = 6;
  localparam int unsigned BIT_SHIFT  = 2;

  // Next enable value for a write; top data bit chooses set or clear.
  function automatic logic [7:0] enable_write(input logic [7:0] cur,
                                              input logic [7:0] data);
    logic [7:0] res;
    if (data[7]) res = cur | {1'b0, data[6:0]};
    else         res = cur & ~data;
    return res;
  endfunction

  // Flag bit update: set dominates clear.
  function automatic logic flag_bit_next(input logic cur, input logic set,
                                         input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/ifc_addr_decode.sv
module ifc_addr_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SEL_LSB = 9,
  parameter int unsigned SEL_W   = ifc_pkg::SEL_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [SEL_W-1:0]  sel,
  output logic              flag_wr,
  output logic              en_wr,
  output logic              cnt_rd
);
  localparam int unsigned SEL_MSB = SEL_LSB + SEL_W - 1;

  always_comb begin
    sel     = addr[SEL_MSB:SEL_LSB];
    flag_wr = wr && (sel == SEL_W'(ifc_pkg::IDX_FLAGS));
    en_wr   = wr && (sel == SEL_W'(ifc_pkg::IDX_ENABLE));
    cnt_rd  = rd && ((sel == SEL_W'(ifc_pkg::IDX_CNT_LO)) ||
                     (sel == SEL_W'(ifc_pkg::IDX_CNT_HI)));
  end
endmodule

// File: rtl/ifc_flag_reg.sv
module ifc_flag_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_vec,
  input  logic [DATA_W-1:0] clr_vec,
  output logic [DATA_W-1:0] flags
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= ifc_pkg::flag_bit_next(flags[i], set_vec[i], clr_vec[i]);
    end
  end
endmodule

// File: rtl/ifc_enable_reg.sv
module ifc_enable_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] enables
);
  always_ff @(posedge clk) begin
    if (!rst_n)      enables <= '0;
    else if (wr_hit) enables <= ifc_pkg::enable_write(enables, wdata);
  end
endmodule

// File: rtl/ifc_irq_out.sv
module ifc_irq_out #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SRC_BIT = ifc_pkg::BIT_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] flags,
  input  logic [DATA_W-1:0] enables,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= flags[SRC_BIT] & enables[SRC_BIT];
  end
endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SEL_LSB = 9,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              timer_evt,
  input  logic              shift_evt,
  output logic [ifc_pkg::SEL_W-1:0] reg_sel,
  output logic              irq
);
  import ifc_pkg::*;

  // Named internal events for the checker.
  logic              flag_wr_hit;
  logic              en_wr_hit;
  logic              timer_rd_clr;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] flag_q;
  logic [DATA_W-1:0] en_q;

  ifc_addr_decode #(.ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .sel(reg_sel),
    .flag_wr(flag_wr_hit), .en_wr(en_wr_hit), .cnt_rd(timer_rd_clr)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_TIMER] = timer_evt;
    set_vec[BIT_SHIFT] = shift_evt;
    clr_vec            = flag_wr_hit ? bus_wdata : '0;
    if (timer_rd_clr) clr_vec[BIT_TIMER] = 1'b1;
  end

  ifc_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flag_q)
  );

  ifc_enable_reg #(.DATA_W(DATA_W)) u_enables (
    .clk(clk), .rst_n(rst_n), .wr_hit(en_wr_hit), .wdata(bus_wdata), .enables(en_q)
  );

  ifc_irq_out #(.DATA_W(DATA_W), .SRC_BIT(BIT_SHIFT)) u_irq (
    .clk(clk), .rst_n(rst_n), .flags(flag_q), .enables(en_q), .irq(irq)
  );

  always_comb begin
    if (reg_sel == SEL_W'(IDX_FLAGS))       bus_rdata = flag_q;
    else if (reg_sel == SEL_W'(IDX_ENABLE)) bus_rdata = en_q;
    else                                    bus_rdata = '0;
  end
endmodule

// File: rtl/ifc_ctrl_chk.sv
module ifc_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flag_wr_hit,
  input logic              en_wr_hit,
  input logic              timer_rd_clr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              timer_evt,
  input logic              shift_evt,
  input logic [DATA_W-1:0] flag_q,
  input logic [DATA_W-1:0] en_q,
  input logic              irq
);
  p_en_msb_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_hit |=> !en_q[7]);

  p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_hit && bus_wdata[7] && bus_wdata[2]) |=> en_q[2]);

  p_en_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_hit && !bus_wdata[7] && bus_wdata[6]) |=> !en_q[6]);

  p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_hit && bus_wdata[2] && !shift_evt) |=> !flag_q[2]);

  p_only_two_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & 8'hBB) == 8'h00);

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_rd_clr && !timer_evt) |=> !flag_q[6]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_evt || shift_evt) |=> (flag_q[6] || !$past(timer_evt)) &&
                                 (flag_q[2] || !$past(shift_evt)));

  p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(flag_q[2] & en_q[2]));
endmodule

bind ifc_ctrl ifc_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_wr_hit(flag_wr_hit), .en_wr_hit(en_wr_hit),
  .timer_rd_clr(timer_rd_clr), .bus_wdata(bus_wdata), .timer_evt(timer_evt),
  .shift_evt(shift_evt), .flag_q(flag_q), .en_q(en_q), .irq(irq)
);

// File: tb/tb_ifc_ctrl.sv
module tb_ifc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        timer_evt = 1'b0;
  logic        shift_evt = 1'b0;
  logic [3:0]  reg_sel;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int unsigned seed_dummy;

  logic [7:0] m_flag = 8'h00;
  logic [7:0] m_en   = 8'h00;
  logic       m_irq  = 1'b0;

  always #5 clk = ~clk;

  ifc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_evt(timer_evt),
    .shift_evt(shift_evt), .reg_sel(reg_sel), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Address with index in bits 12:9 and random other bits.
  function automatic logic [15:0] mk_addr(input logic [3:0] idx);
    logic [15:0] a;
    a = 16'($urandom);
    a[12:9] = idx;
    return a;
  endfunction

  function automatic logic [7:0] exp_en(input logic [7:0] cur, input logic [7:0] d);
    logic [7:0] r;
    r = cur;
    for (int i = 0; i < 7; i++) begin
      if (d[i]) r[i] = d[7];
    end
    r[7] = 1'b0;
    return r;
  endfunction

  // One bus cycle plus model update and port checks.
  task automatic step(input string tag, input logic [3:0] idx, input logic wr,
                      input logic rd, input logic [7:0] d, input logic te, input logic se);
    logic [7:0] nf;
    bus_addr = mk_addr(idx); bus_wr = wr; bus_rd = rd; bus_wdata = d;
    timer_evt = te; shift_evt = se;
    #1;
    check({tag, " R1 sel"}, {4'h0, reg_sel}, {4'h0, idx});
    @(posedge clk);
    m_irq = m_flag[2] & m_en[2];
    nf = m_flag;
    if (wr && idx == 4'd13) nf = nf & ~d;
    if (rd && (idx == 4'd4 || idx == 4'd5)) nf[6] = 1'b0;
    if (te) nf[6] = 1'b1;
    if (se) nf[2] = 1'b1;
    if (wr && idx == 4'd14) m_en = exp_en(m_en, d);
    m_flag = nf;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; timer_evt = 1'b0; shift_evt = 1'b0;
    check({tag, " R8 irq"}, {7'h0, irq}, {7'h0, m_irq});
    bus_addr = mk_addr(4'd13); #1;
    check({tag, " R10 flags"}, bus_rdata, m_flag);
    bus_addr = mk_addr(4'd14); #1;
    check({tag, " R10 enables"}, bus_rdata, m_en);
    bus_addr = mk_addr(4'($urandom_range(0, 12))); #1;
    check({tag, " R10 other"}, bus_rdata, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    seed_dummy = $urandom(32'h1234_5678);
    // R9: reset state, with events asserted during reset.
    timer_evt = 1'b1; shift_evt = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    timer_evt = 1'b0; shift_evt = 1'b0;
    bus_addr = mk_addr(4'd13); #1; check("R9 flags", bus_rdata, 8'h00);
    bus_addr = mk_addr(4'd14); #1; check("R9 enables", bus_rdata, 8'h00);
    check("R9 irq", {7'h0, irq}, 8'h00);
    rst_n = 1'b1;

    // R2: set mode with all bits, bit 7 must stay 0.
    step("R2", 4'd14, 1, 0, 8'hFF, 0, 0);
    check("R2 en", m_en, 8'h7F);
    // R3: clear mode.
    step("R3", 4'd14, 1, 0, 8'h41, 0, 0);
    check("R3 en", m_en, 8'h3E);
    // R5 / R8: shift event with enable bit 2 set.
    step("R5", 4'd0, 0, 0, 8'h00, 0, 1);
    step("R8", 4'd0, 0, 0, 8'h00, 0, 0);
    check("R8 irq high", {7'h0, irq}, 8'h01);
    // R4: clear flag 2 by writing ones.
    step("R4", 4'd13, 1, 0, 8'h04, 0, 0);
    step("R4", 4'd0, 0, 0, 8'h00, 0, 0);
    check("R4 irq low", {7'h0, irq}, 8'h00);
    // R8: timer flag with its enable set does not raise irq.
    step("R8", 4'd14, 1, 0, 8'hC0, 1, 0);
    step("R8", 4'd0, 0, 0, 8'h00, 0, 0);
    check("R8 timer no irq", {7'h0, irq}, 8'h00);
    // R6: read index 6 keeps flag, index 5 clears it, index 4 too.
    step("R6", 4'd6, 0, 1, 8'h00, 0, 0);
    check("R6 keep", m_flag, 8'h40);
    step("R6", 4'd5, 0, 1, 8'h00, 0, 0);
    check("R6 clr5", m_flag, 8'h00);
    step("R6", 4'd0, 0, 0, 8'h00, 1, 0);
    step("R6", 4'd4, 0, 1, 8'h00, 0, 0);
    // R7: set and clear in same cycle.
    step("R7", 4'd4, 0, 1, 8'h00, 1, 0);
    check("R7 read vs set", m_flag, 8'h40);
    step("R7", 4'd13, 1, 0, 8'hFF, 1, 1);
    check("R7 write vs set", m_flag, 8'h44);
    // R1: writes to other indexes change nothing.
    step("R1", 4'd12, 1, 0, 8'hFF, 0, 0);
    step("R1", 4'd15, 1, 0, 8'h00, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] idx;
      logic wr, rd;
      idx = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(13, 14)) : 4'($urandom);
      wr = ($urandom_range(0, 2) == 0);
      rd = !wr && ($urandom_range(0, 2) == 0);
      step("rand", idx, wr, rd, 8'($urandom), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 4) == 0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule